// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is a synthesizable pin-level model of a small nonvolatile serial memory. A host selects it with chip select and clocks in commands one bit per shift-clock rising edge. Each command is a start bit, a two-bit operation code and an address, and some commands add a data word. The block answers reads on a serial data output and shows a separate enable that stands for the high-impedance state. The storage is a register file of bytes. An organization input picks either 8-bit words with a 9-bit address or 16-bit words with an 8-bit address.

All three serial inputs are synchronized into the system clock and edge-detected there. Programming commands (write, erase, erase-all, write-all) run a self-timed busy period of a parameterized number of system-clock cycles. During that period the host can drop chip select and raise it again to poll ready/busy on the data output. A write-enable latch guards every programming command.

Top module: `serial_nvm_slave`

## Requirements
- R1: Serial bits are taken on shift-clock rising edges while chip select is high. Zeros before the first 1 are skipped. That 1 is the start bit, and the next two bits are the operation code: 10 read, 01 write, 11 erase one word, 00 extended. For 00, the two most significant address bits choose the action: 11 enable programming, 00 disable programming, 10 erase all, 01 write all. All address bits are still clocked in.
- R2: On a read, the rising edge that delivers the last address bit enables the output and drives a single 0. Each later rising edge presents the next data bit, most significant bit first.
- R3: While chip select stays high, a read continues with the next address and no dummy bit. The address wraps from the last location to 0.
- R4: With the organization input at 0, words are 8 bits and addresses are 9 bits. With it at 1, words are 16 bits and addresses are 8 bits. Word n of the 16-bit view is byte 2n (upper half) and byte 2n+1 (lower half) of the 8-bit view.
- R5: After reset, every byte reads 0xFF and programming is disabled. Write, erase, erase-all and write-all change nothing until the enable command. The disable command turns that protection back on.
- R6: Read returns stored data whether programming is enabled or disabled.
- R7: Write stores its data word at the addressed location without a prior erase.
- R8: Erase sets every bit of the addressed word to 1. Erase-all sets every bit of the array to 1.
- R9: Write-all stores the data word in every location.
- R10: An accepted programming command starts a busy period when its last bit arrives. If chip select is lowered and raised during that period, the output is enabled and shows 0 while busy and 1 once ready. If chip select is raised only after the period has ended, the output stays disabled.
- R11: Any command clocked in while busy is ignored.
- R12: The output enable is low while chip select is low, during command and data input, and after a non-read command has been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial shift clock |
| din_i | input | 1 | Serial data in |
| org16_i | input | 1 | Organization: 1 selects 16-bit words, 0 selects 8-bit words |
| dout_o | output | 1 | Serial data out or ready/busy status |
| dout_en_o | output | 1 | Data-out enable; low models high impedance |

## Verification
The assertions assume that chip select, the shift clock and data in each hold steady for several system clocks around every change. This lets the synchronizers see every shift-clock edge exactly once. They also assume that the organization input changes only while chip select is low. The stimulus keeps each shift-clock half-period at six system clocks and changes data in only while the shift clock is low. Between each chip-select change and the next shift-clock edge it leaves a full half-period, and it alters the organization only between commands. Status polls are placed well inside or well past the busy period, so no expected value depends on the exact cycle the busy period ends.

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave #(
  parameter int ABITS       = 9,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic din_i,
  input  logic org16_i,
  output logic dout_o,
  output logic dout_en_o
);

  localparam int DEPTH = 1 << ABITS;
  localparam int PC_W  = $clog2(PROG_CYCLES + 1);
  localparam int CNT_W = $clog2(ABITS + 16);
  localparam logic [CNT_W-1:0] LAST_A8  = CNT_W'(ABITS + 1);
  localparam logic [CNT_W-1:0] LAST_A16 = CNT_W'(ABITS);
  localparam logic [CNT_W-1:0] LAST_D8  = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_D16 = CNT_W'(15);
  localparam logic [PC_W-1:0]  PC_LOAD  = PC_W'(PROG_CYCLES);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_STAT, S_HOLD} state_t;

  logic [2:0]       cs_q, sck_q;
  logic [1:0]       din_q;
  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       op;
  logic [ABITS-1:0] addr, ptr;
  logic [15:0]      data, sh;
  logic             fill_all, wen;
  logic [PC_W-1:0]  pc;
  logic [7:0]       mem [0:DEPTH-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= '0;
      sck_q <= '0;
      din_q <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_i};
      sck_q <= {sck_q[1:0], sck_i};
      din_q <= {din_q[0], din_i};
    end

  logic cs_on, cs_rise, sck_rise, din_s, busy, step;
  assign cs_on    = cs_q[1];
  assign cs_rise  = cs_q[1] & ~cs_q[2];
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign din_s    = din_q[1];
  assign busy     = pc != '0;
  assign step     = cs_on & ~cs_rise & sck_rise;

  logic [ABITS-1:0] a_nxt, ptr_inc;
  logic [15:0]      d_nxt, rd_word;
  logic [1:0]       ext;
  assign a_nxt = {addr[ABITS-2:0], din_s};
  assign d_nxt = {data[14:0], din_s};
  assign ext   = org16_i ? a_nxt[ABITS-2:ABITS-3] : a_nxt[ABITS-1:ABITS-2];

  logic last_cmd, last_data;
  assign last_cmd  = step && state == S_CMD  && cnt == (org16_i ? LAST_A16 : LAST_A8);
  assign last_data = step && state == S_DATA && cnt == (org16_i ? LAST_D16 : LAST_D8);

  logic do_erase, do_eral, do_write, do_wral, prog_start;
  assign do_erase   = last_cmd  && op == 2'b11 && wen;
  assign do_eral    = last_cmd  && op == 2'b00 && ext == 2'b10 && wen;
  assign do_write   = last_data && !fill_all && wen;
  assign do_wral    = last_data &&  fill_all && wen;
  assign prog_start = do_erase | do_eral | do_write | do_wral;

  assign rd_word = org16_i ? {mem[{ptr[ABITS-2:0], 1'b0}], mem[{ptr[ABITS-2:0], 1'b1}]}
                           : {mem[ptr], 8'h00};
  assign ptr_inc = org16_i ? {1'b0, ptr[ABITS-2:0] + 1'b1} : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (do_eral) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (do_wral) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (org16_i && (i % 2 == 0)) ? d_nxt[15:8] : d_nxt[7:0];
    end else if (do_erase) begin
      if (org16_i) begin
        mem[{a_nxt[ABITS-2:0], 1'b0}] <= '1;
        mem[{a_nxt[ABITS-2:0], 1'b1}] <= '1;
      end else
        mem[a_nxt] <= '1;
    end else if (do_write) begin
      if (org16_i) begin
        mem[{addr[ABITS-2:0], 1'b0}] <= d_nxt[15:8];
        mem[{addr[ABITS-2:0], 1'b1}] <= d_nxt[7:0];
      end else
        mem[addr] <= d_nxt[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          pc <= '0;
    else if (prog_start) pc <= PC_LOAD;
    else if (busy)       pc <= pc - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      op        <= '0;
      addr      <= '0;
      data      <= '0;
      ptr       <= '0;
      sh        <= '0;
      fill_all  <= 1'b0;
      wen       <= 1'b0;
      dout_o    <= 1'b0;
      dout_en_o <= 1'b0;
    end else if (!cs_on) begin
      state     <= S_IDLE;
      dout_o    <= 1'b0;
      dout_en_o <= 1'b0;
    end else if (cs_rise) begin
      cnt <= '0;
      if (busy) begin
        state     <= S_STAT;
        dout_o    <= 1'b0;
        dout_en_o <= 1'b1;
      end else
        state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:
          if (sck_rise && din_s) begin
            state <= S_CMD;
            cnt   <= '0;
          end
        S_CMD:
          if (sck_rise) begin
            cnt <= cnt + 1'b1;
            if (cnt < CNT_W'(2)) op <= {op[0], din_s};
            else                 addr <= a_nxt;
            if (last_cmd) begin
              cnt   <= '0;
              state <= S_HOLD;
              case (op)
                2'b10: begin
                  state     <= S_READ;
                  dout_o    <= 1'b0;
                  dout_en_o <= 1'b1;
                  ptr       <= org16_i ? {1'b0, a_nxt[ABITS-2:0]} : a_nxt;
                end
                2'b01: begin
                  state    <= S_DATA;
                  fill_all <= 1'b0;
                end
                2'b00:
                  case (ext)
                    2'b11: wen <= 1'b1;
                    2'b00: wen <= 1'b0;
                    2'b01: begin
                      state    <= S_DATA;
                      fill_all <= 1'b1;
                    end
                    default: ;
                  endcase
                default: ;
              endcase
            end
          end
        S_DATA:
          if (sck_rise) begin
            data <= d_nxt;
            cnt  <= cnt + 1'b1;
            if (last_data) state <= S_HOLD;
          end
        S_READ:
          if (sck_rise) begin
            if (cnt == '0) begin
              dout_o <= rd_word[15];
              sh     <= {rd_word[14:0], 1'b0};
              cnt    <= org16_i ? LAST_D16 : LAST_D8;
              ptr    <= ptr_inc;
            end else begin
              dout_o <= sh[15];
              sh     <= {sh[14:0], 1'b0};
              cnt    <= cnt - 1'b1;
            end
          end
        S_STAT: dout_o <= ~busy;
        default: ;
      endcase
    end

endmodule

// File: rtl/nvm_checks.sv
module nvm_checks (
  input logic clk,
  input logic rst_n,
  input logic cs_i,
  input logic cs_on,
  input logic busy,
  input logic wen,
  input logic prog_start,
  input logic dout_o,
  input logic dout_en_o
);

  assert_hiz_deselected_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> ##3 !dout_en_o);

  assert_prog_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);

  assert_no_start_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_start);

  assert_status_busy_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dout_en_o) |-> !dout_o);

  assert_status_ready_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && dout_en_o && cs_on) |=> dout_o);

  assert_first_bit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en_o) |-> !dout_o);

endmodule

bind serial_nvm_slave nvm_checks u_chk (
  .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .cs_on(cs_on), .busy(busy), .wen(wen),
  .prog_start(prog_start), .dout_o(dout_o), .dout_en_o(dout_en_o)
);

// File: tb/sim_serial_nvm_slave.sv
module sim_serial_nvm_slave;
  localparam int ABITS = 9;
  localparam int PROG  = 80;
  localparam int H     = 6;

  logic clk = 0, rst_n = 0, cs = 0, sck = 0, din = 0, org16 = 0;
  wire  dout, dout_en;

  always #5 clk = ~clk;

  serial_nvm_slave #(.ABITS(ABITS), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .din_i(din),
    .org16_i(org16), .dout_o(dout), .dout_en_o(dout_en));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errs = 0, blank = 0;
  string req = "R12";
  bit done = 0;
  logic exp_en = 0, exp_do = 0;
  logic [7:0] ref_mem [0:511];
  int m_state = 0;
  int mcnt, mcmd, mop, maddr, mdata, mptr;
  bit mall, mwen = 0;
  int ready_at = -1000;
  bit bq[$];
  bit near_edge;
  logic edo;

  function automatic int aw();  return org16 ? ABITS - 1 : ABITS; endfunction
  function automatic int ww();  return org16 ? 16 : 8; endfunction
  function automatic int dep(); return 1 << aw(); endfunction

  function automatic int get_word(int a);
    if (org16) return int'({ref_mem[2*a], ref_mem[2*a+1]});
    return int'(ref_mem[a]);
  endfunction

  task automatic put_word(int a, int v);
    if (org16) begin
      ref_mem[2*a]   = 8'((v >> 8) & 255);
      ref_mem[2*a+1] = 8'(v & 255);
    end else
      ref_mem[a] = 8'(v & 255);
  endtask

  task automatic start_prog();
    ready_at = cyc + PROG + 4;
  endtask

  task automatic model_cs_rise();
    if (cyc < ready_at) begin
      m_state = 4;
      exp_en  = 1;
    end else
      m_state = 0;
  endtask

  task automatic model_bit(bit b);
    int w, ext;
    case (m_state)
      0: if (b) begin m_state = 1; mcnt = 0; mcmd = 0; end
      1: begin
        mcmd = mcmd * 2 + int'(b);
        mcnt++;
        if (mcnt == 2 + aw()) begin
          mop   = mcmd >> aw();
          maddr = mcmd & (dep() - 1);
          m_state = 5;
          case (mop)
            2: begin m_state = 3; exp_en = 1; exp_do = 0; bq.delete(); mptr = maddr; end
            1: begin m_state = 2; mall = 0; mcnt = 0; mdata = 0; end
            3: if (mwen) begin put_word(maddr, (1 << ww()) - 1); start_prog(); end
            default: begin
              ext = maddr >> (aw() - 2);
              case (ext)
                3: mwen = 1;
                0: mwen = 0;
                2: if (mwen) begin
                     for (int a = 0; a < 512; a++) ref_mem[a] = 8'hFF;
                     start_prog();
                   end
                default: begin m_state = 2; mall = 1; mcnt = 0; mdata = 0; end
              endcase
            end
          endcase
        end
      end
      2: begin
        mdata = mdata * 2 + int'(b);
        mcnt++;
        if (mcnt == ww()) begin
          m_state = 5;
          if (mwen) begin
            if (mall) for (int a = 0; a < dep(); a++) put_word(a, mdata);
            else      put_word(maddr, mdata);
            start_prog();
          end
        end
      end
      3: begin
        if (bq.size() == 0) begin
          w = get_word(mptr);
          for (int k = ww() - 1; k >= 0; k--) bq.push_back(bit'((w >> k) & 1));
          mptr = (mptr + 1) % dep();
        end
        exp_do = bq.pop_front();
      end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (blank > 0) blank--;
      else begin
        edo = exp_do;
        near_edge = 0;
        if (m_state == 4) begin
          edo = (cyc >= ready_at);
          near_edge = (cyc - ready_at <= 2) && (ready_at - cyc <= 2);
        end
        if (!near_edge) begin
          checks++;
          if (dout_en !== exp_en || (exp_en && dout !== edo)) begin
            errs++;
            $display("FAIL %s: cycle %0d dout_en=%b dout=%b expected dout_en=%b dout=%b",
                     req, cyc, dout_en, dout, exp_en, edo);
          end
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cs_up();
    cs = 1; model_cs_rise(); blank = 4; tick(H);
  endtask

  task automatic cs_down();
    sck = 0; cs = 0; exp_en = 0; m_state = 0; blank = 4; tick(H);
  endtask

  task automatic send_bit(bit b);
    din = b; tick(H);
    sck = 1; model_bit(b); blank = 4; tick(H);
    sck = 0;
  endtask

  task automatic send(int v, int n);
    for (int k = n - 1; k >= 0; k--) send_bit(bit'((v >> k) & 1));
  endtask

  task automatic command(int op, int a);
    send_bit(1); send(op, 2); send(a, aw());
  endtask

  task automatic wr(int a, int v);
    cs_up(); command(1, a); send(v, ww()); cs_down();
  endtask

  task automatic ext_cmd(int code, int v, bit with_data);
    cs_up(); command(0, code << (aw() - 2));
    if (with_data) send(v, ww());
    cs_down();
  endtask

  task automatic rd(int a, int n);
    cs_up(); command(2, a);
    repeat (n) send(0, ww());
    cs_down();
  endtask

  task automatic wait_ready();
    tick(PROG + 20);
  endtask

  task automatic poll_status();
    cs_up(); tick(4 * H); tick(PROG + 10); cs_down();
  endtask

  initial begin
    for (int a = 0; a < 512; a++) ref_mem[a] = 8'hFF;
    req = "R12"; tick(10); rst_n = 1; tick(10);
    req = "R2";  rd(5, 1);
    req = "R6";  rd(9, 2);
    req = "R1";  cs_up(); send_bit(0); send_bit(0); send_bit(0); command(2, 5); send(0, 8); cs_down();
    req = "R5";  wr(5, 'h3C); cs_up(); tick(30); cs_down(); rd(5, 1);
    req = "R1";  ext_cmd(3, 0, 0);
    req = "R7";  wr(5, 'h3C);
    req = "R10"; poll_status();
    req = "R7";  rd(5, 1);
    req = "R10"; wr(6, 'hA5); wait_ready(); cs_up(); tick(30); cs_down();
    req = "R3";  wr(0, 'h11); wait_ready(); rd(5, 3); rd(511, 2);
    req = "R8";  cs_up(); command(3, 5); cs_down(); wait_ready(); rd(5, 1);
    req = "R11"; wr(7, 'h77); cs_up(); command(1, 6); send(0, 8); cs_down(); wait_ready(); rd(6, 2);
    req = "R4";  org16 = 1; tick(H); wr(3, 'hBEEF); wait_ready(); rd(3, 1);
                 org16 = 0; tick(H); rd(6, 2);
    req = "R9";  org16 = 1; tick(H); ext_cmd(1, 'h1234, 1); wait_ready(); rd(255, 2);
    req = "R8";  ext_cmd(2, 0, 0); wait_ready(); rd(0, 2);
    req = "R5";  ext_cmd(0, 0, 0); wr(1, 'h0000); cs_up(); tick(30); cs_down(); rd(1, 1);
    req = "R12"; tick(20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL %s: watchdog expired, actual=running expected=finished", req);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule